// File: doc/BRIEF.md
# Supply-Loss Access Guard Sequencer

This block sits between a memory's bus controls and its array. It takes digital flags from external supply comparators and decides when the array may be selected. A supply-low flag drops the active-low interrupt on the next clock. The bus stays usable for a programmable number of microsecond ticks, and then the block locks the array out. A battery flag locks the array at once and is reported on its own output.

When the supply returns, the lockout is held for a programmable recovery window. The interrupt is released part way through that window. Bus decode is two chip enables, one active low and one active high. A read drives the data bus when the output enable is low and the write strobe is high. A low write strobe makes a write and always frees the data bus.

All timing is counted in pulses of a microsecond tick input. The default delays are 20 ticks to lockout, 80 ticks to interrupt release and 1000 ticks to the end of the lockout.

Top module: `supply_guard_seq`

## Requirements
- R1: `mem_sel_o` is 1 only when the block allows access, `chip_en_n_i` is 0 and `chip_en_i` is 1. When it is 0, `mem_wr_o` and `bus_drive_o` are also 0.
- R2: While selected, `bus_drive_o` equals (`out_en_n_i`==0 and `wr_en_n_i`==1), and `mem_wr_o` equals (`wr_en_n_i`==0).
- R3: A low `wr_en_n_i` forces `bus_drive_o` to 0, even when `out_en_n_i` is 0.
- R4: From normal operation, a 1 on `supply_low_i` drives `irq_n_o` to 0 after the next rising clock edge.
- R5: Access stays allowed while the lockout delay runs. After the clock edge that samples the DESELECT_US-th tick since the interrupt fell, access is blocked.
- R6: While access is blocked, `mem_sel_o`, `mem_wr_o` and `bus_drive_o` are 0 for any value of the bus controls.
- R7: A 1 on `on_batt_i` sets `on_battery_o` after the next edge. On that same edge access is blocked and `irq_n_o` is 0, from any state.
- R8: Once both flags are clear in lockout, the next edge starts the recovery count. Access returns after the edge that samples the RECOVER_US-th tick.
- R9: `irq_n_o` stays 0 through recovery until RELEASE_US ticks have been counted, and is 1 after that.
- R10: If `supply_low_i` clears during the lockout delay, the lockout still happens on schedule, and the recovery count begins only after it.
- R11: A supply-low or battery flag during recovery returns the block to lockout with `irq_n_o` at 0. The next recovery counts again from zero.
- R12: After reset, `irq_n_o` is 1, `on_battery_o` is 0 and access is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_low_i | input | 1 | Supply is below the power-fail trip point |
| on_batt_i | input | 1 | Supply is below the battery switchover level |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| chip_en_n_i | input | 1 | Active-low chip enable |
| chip_en_i | input | 1 | Active-high chip enable |
| out_en_n_i | input | 1 | Active-low output enable |
| wr_en_n_i | input | 1 | Active-low write strobe |
| irq_n_o | output | 1 | Active-low power-fail interrupt |
| mem_sel_o | output | 1 | Internal array select |
| mem_wr_o | output | 1 | Internal array write enable |
| bus_drive_o | output | 1 | Data bus output enable |
| on_battery_o | output | 1 | Battery-backup mode indication |

## Verification
The bench counts ticks across each window boundary and checks the outputs one tick before the edge and on the edge itself. An off-by-one in the lockout delay, the interrupt release or the recovery count shows up as a select or interrupt that changes one tick early or late. A supply dip that ends inside the lockout delay catches a design that returns straight to normal operation and skips the write protection. A loss during recovery catches a timer that resumes from its old count instead of restarting from zero. With write strobe and output enable both low, a design that drives the bus during a write is caught by the read/write contention check.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef enum logic [1:0] {
        SG_RUN     = 2'd0,
        SG_WARN    = 2'd1,
        SG_LOCK    = 2'd2,
        SG_RECOVER = 2'd3
    } sg_state_e;

    typedef struct packed {
        sg_state_e state;
        logic      batt;
    } sg_regs_t;

endpackage

// File: rtl/sg_us_timer.sv
module sg_us_timer #(
    parameter int CW   = 10,
    parameter int MAXV = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LIMIT = CW'(MAXV);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
    import supply_guard_pkg::*;
#(
    parameter int DESELECT_US = 20,
    parameter int RELEASE_US  = 80,
    parameter int RECOVER_US  = 1000,
    parameter int CW          = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_low_i,
    input  logic          on_batt_i,
    input  logic          tick_i,
    input  logic [CW-1:0] cnt_i,
    output logic          clr_o,
    output logic          access_ok_o,
    output logic          irq_n_o,
    output logic          batt_o
);

    localparam logic [CW-1:0] DLY_LAST = CW'(DESELECT_US - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(RECOVER_US - 1);
    localparam logic [CW-1:0] REL_AT   = CW'(RELEASE_US);

    sg_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.batt = on_batt_i;
        unique case (r_q.state)
            SG_RUN: begin
                if (on_batt_i) begin
                    r_d.state = SG_LOCK;
                end else if (supply_low_i) begin
                    r_d.state = SG_WARN;
                end
            end
            SG_WARN: begin
                if (on_batt_i || (tick_i && (cnt_i == DLY_LAST))) begin
                    r_d.state = SG_LOCK;
                end
            end
            SG_LOCK: begin
                if (!on_batt_i && !supply_low_i) begin
                    r_d.state = SG_RECOVER;
                end
            end
            SG_RECOVER: begin
                if (on_batt_i || supply_low_i) begin
                    r_d.state = SG_LOCK;
                end else if (tick_i && (cnt_i == REC_LAST)) begin
                    r_d.state = SG_RUN;
                end
            end
            default: r_d.state = SG_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SG_RUN;
            r_q.batt  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign clr_o       = (r_d.state != r_q.state);
    assign access_ok_o = (r_q.state == SG_RUN) || (r_q.state == SG_WARN);
    assign batt_o      = r_q.batt;

    always_comb begin
        unique case (r_q.state)
            SG_RUN:     irq_n_o = 1'b1;
            SG_RECOVER: irq_n_o = (cnt_i >= REL_AT);
            default:    irq_n_o = 1'b0;
        endcase
    end

    AST_IRQ_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SG_RUN && supply_low_i) |=> !irq_n_o); // R4

    AST_WARN_NO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SG_WARN) |=> (r_q.state != SG_RUN)); // R10

    AST_REOPEN_FROM_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok_o) |-> ($past(r_q.state) == SG_RECOVER)); // R8

endmodule

// File: rtl/sg_bus_gate.sv
module sg_bus_gate (
    input  logic access_ok_i,
    input  logic chip_en_n_i,
    input  logic chip_en_i,
    input  logic out_en_n_i,
    input  logic wr_en_n_i,
    output logic sel_o,
    output logic wr_o,
    output logic drive_o
);

    always_comb begin
        sel_o   = access_ok_i && !chip_en_n_i && chip_en_i;
        wr_o    = sel_o && !wr_en_n_i;
        drive_o = sel_o && !out_en_n_i && wr_en_n_i;
    end

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq #(
    parameter int DESELECT_US = 20,
    parameter int RELEASE_US  = 80,
    parameter int RECOVER_US  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic on_batt_i,
    input  logic us_tick_i,
    input  logic chip_en_n_i,
    input  logic chip_en_i,
    input  logic out_en_n_i,
    input  logic wr_en_n_i,
    output logic irq_n_o,
    output logic mem_sel_o,
    output logic mem_wr_o,
    output logic bus_drive_o,
    output logic on_battery_o
);

    localparam int CW = $clog2(RECOVER_US + 1);

    logic          tmr_clr;
    logic [CW-1:0] tmr_cnt;
    logic          access_ok;

    sg_us_timer #(
        .CW   (CW),
        .MAXV (RECOVER_US)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_i (us_tick_i),
        .cnt_o  (tmr_cnt)
    );

    sg_fsm #(
        .DESELECT_US (DESELECT_US),
        .RELEASE_US  (RELEASE_US),
        .RECOVER_US  (RECOVER_US),
        .CW          (CW)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (supply_low_i),
        .on_batt_i    (on_batt_i),
        .tick_i       (us_tick_i),
        .cnt_i        (tmr_cnt),
        .clr_o        (tmr_clr),
        .access_ok_o  (access_ok),
        .irq_n_o      (irq_n_o),
        .batt_o       (on_battery_o)
    );

    sg_bus_gate i_gate (
        .access_ok_i (access_ok),
        .chip_en_n_i (chip_en_n_i),
        .chip_en_i   (chip_en_i),
        .out_en_n_i  (out_en_n_i),
        .wr_en_n_i   (wr_en_n_i),
        .sel_o       (mem_sel_o),
        .wr_o        (mem_wr_o),
        .drive_o     (bus_drive_o)
    );

    AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_o |-> wr_en_n_i); // R3

    AST_BATTERY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        on_battery_o |-> (!mem_sel_o && !irq_n_o)); // R7

endmodule

// File: tb/test_supply_guard_seq.sv
module test_supply_guard_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DLY = 5;
    localparam int REL = 8;
    localparam int REC = 20;

    // {chip_en_n, chip_en, out_en_n, wr_en_n, exp_sel, exp_wr, exp_drive}
    localparam logic [6:0] VEC [16] = '{
        7'b0000_000, 7'b0001_000, 7'b0010_000, 7'b0011_000,
        7'b0100_110, 7'b0101_101, 7'b0110_110, 7'b0111_100,
        7'b1000_000, 7'b1001_000, 7'b1010_000, 7'b1011_000,
        7'b1100_000, 7'b1101_000, 7'b1110_000, 7'b1111_000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0, on_batt = 1'b0, tick = 1'b0;
    logic ce_n = 1'b1, ce = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic irq_n, sel, wr, drv, batt_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_guard_seq #(
        .DESELECT_US (DLY),
        .RELEASE_US  (REL),
        .RECOVER_US  (REC)
    ) i_supply_guard_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (supply_low),
        .on_batt_i    (on_batt),
        .us_tick_i    (tick),
        .chip_en_n_i  (ce_n),
        .chip_en_i    (ce),
        .out_en_n_i   (oe_n),
        .wr_en_n_i    (we_n),
        .irq_n_o      (irq_n),
        .mem_sel_o    (sel),
        .mem_wr_o     (wr),
        .bus_drive_o  (drv),
        .on_battery_o (batt_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            step();
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write();
        ce_n = 1'b0; ce = 1'b1; oe_n = 1'b1; we_n = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        bus_write();
        step();
        // R12 reset state
        check("R12 irq_n", irq_n, 1'b1);
        check("R12 on_battery", batt_o, 1'b0);
        check("R12 access", sel, 1'b1);

        // R1 R2 R3 decode table
        for (int i = 0; i < 16; i++) begin
            {ce_n, ce, oe_n, we_n} = VEC[i][6:3];
            #1;
            check("R1 sel", sel, VEC[i][2]);
            check("R2 wr", wr, VEC[i][1]);
            check("R3 drive", drv, VEC[i][0]);
        end

        // R4 R5 lockout delay
        bus_write();
        supply_low = 1'b1;
        step();
        check("R4 irq low", irq_n, 1'b0);
        check("R5 write during delay", wr, 1'b1);
        ticks(DLY - 1);
        check("R5 still selected", sel, 1'b1);
        ticks(1);
        check("R5 deselected", sel, 1'b0);
        check("R5 write blocked", wr, 1'b0);
        // R6 inputs ignored while locked
        oe_n = 1'b0; we_n = 1'b1;
        #1;
        check("R6 no drive", drv, 1'b0);
        check("R6 no sel", sel, 1'b0);

        // R8 R9 recovery
        supply_low = 1'b0;
        step();
        check("R9 irq held", irq_n, 1'b0);
        ticks(REL - 1);
        check("R9 irq before release", irq_n, 1'b0);
        ticks(1);
        check("R9 irq released", irq_n, 1'b1);
        check("R8 still blocked", sel, 1'b0);
        ticks(REC - REL - 1);
        check("R8 blocked last tick", sel, 1'b0);
        ticks(1);
        check("R8 access back", sel, 1'b1);
        check("R2 read drives", drv, 1'b1);

        // R10 dip ending inside the delay
        supply_low = 1'b1;
        step();
        ticks(2);
        supply_low = 1'b0;
        ticks(DLY - 2);
        check("R10 locked anyway", sel, 1'b0);
        check("R10 irq low", irq_n, 1'b0);
        ticks(REC - 1);
        check("R10 recovery not done", sel, 1'b0);
        ticks(1);
        check("R10 recovery done", sel, 1'b1);

        // R11 loss during recovery
        supply_low = 1'b1;
        step();
        ticks(DLY);
        supply_low = 1'b0;
        step();
        ticks(REC - 3);
        check("R11 irq released", irq_n, 1'b1);
        supply_low = 1'b1;
        step();
        check("R11 irq again", irq_n, 1'b0);
        check("R11 blocked", sel, 1'b0);
        supply_low = 1'b0;
        step();
        ticks(REC - 1);
        check("R11 count restarted", sel, 1'b0);
        ticks(1);
        check("R11 access back", sel, 1'b1);

        // R7 battery flag
        supply_low = 1'b1;
        on_batt = 1'b1;
        step();
        check("R7 on_battery", batt_o, 1'b1);
        check("R7 immediate lock", sel, 1'b0);
        check("R7 irq low", irq_n, 1'b0);
        on_batt = 1'b0;
        step();
        check("R7 on_battery clear", batt_o, 1'b0);
        check("R7 still locked", sel, 1'b0);
        supply_low = 1'b0;
        step();
        ticks(REC);
        check("R7 access after recovery", sel, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule